// File: doc/BRIEF.md
# Page Hamming ECC Generator

This block sits beside the byte data path of a NAND flash host and computes a single-error-correcting Hamming code over a 512-byte page while the bytes stream past. The page is split into two 256-byte halves, each with its own independent code of 16 line-parity bits and 6 column-parity bits. Since each half can locate and fix one flipped bit, a page tolerates up to two bit errors in total, provided they fall in different halves. Correction is not done here: the block only produces the check bytes.

The host drives the block through mode codes written to the mode input. One code clears the engine; the host then does one throw-away read. A second code starts accumulation over the data bytes that follow. A third code turns the 16-bit read port into a result port that returns the six check bytes over three reads in a fixed interleaved order. After the last of those reads, the mode falls back to plain data mode by itself.

Top module: `page_ecc_gen`

## Requirements
- R1: Writing mode 0xF4 clears the parity state of both halves and the byte count, so that results read right afterwards are 0xFFFF on every word. A 16-bit read made while the mode is 0xF4 (the dummy read) changes neither `mode_q` nor the parity state.
- R2: After mode 0xB4 is written, every cycle with `byte_vld` high and no mode write in that cycle adds `byte_dat` to the code. Bytes offered in any other mode leave the code unchanged.
- R3: Accepted bytes 0 to 255 feed the first half and bytes 256 to 511 feed the second half. Any byte offered after 512 accepted bytes is ignored until the next 0xF4.
- R4: For a byte at half-relative address a with XOR parity p, and for each address bit k from 0 to 7: line bit 2k accumulates p when bit k of a is 0, and line bit 2k+1 accumulates p when bit k of a is 1.
- R5: For each bit-index bit j from 0 to 2: column bit 2j accumulates every data bit whose bit index has bit j equal to 0, and column bit 2j+1 accumulates every data bit whose bit index has bit j equal to 1.
- R6: Every parity bit is reported inverted, so a page of all 0xFF bytes gives 0xFF in all six check bytes. A check byte built from column parity carries the six inverted column bits in bits 7..2 and binary 11 in bits 1..0.
- R7: In mode 0xD4, the three successive reads return the following words: {~line1st[15:8], ~line1st[7:0]}, then {~line2nd[7:0], colbyte1st}, then {colbyte2nd, ~line2nd[15:8]}. Each `word_rd` strobe advances to the next word.
- R8: The third result read sets `mode_q` to 0x94. `word_rdata` is 0 in every mode other than 0xD4.
- R9: `mode_q` shows the last mode code written (0x00 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 8 | Mode code being written |
| byte_vld | input | 1 | A data byte passes the data path this cycle |
| byte_dat | input | 8 | Data byte value |
| word_rd | input | 1 | 16-bit data read strobe |
| word_rdata | output | 16 | Result word in result mode, otherwise 0 |
| mode_q | output | 8 | Current mode code |

## Verification
The assertions assume that the host does not write a mode and offer a byte in the same cycle, and that a read strobe during result mode never comes with a mode write. The stimulus keeps these apart: every mode write, byte and read strobe is a separate one-cycle step. The bench computes the expected check bytes straight from the bit-level line and column definitions, over the whole page and over its two halves. It does not use a running column XOR.

// File: rtl/pecc_pkg.sv
package pecc_pkg;
    localparam int BYTE_W     = 8;
    localparam int HALF_BYTES = 256;
    localparam int HALVES     = 2;
    localparam int PAGE_BYTES = HALF_BYTES * HALVES;
    localparam int ADDR_W     = $clog2(HALF_BYTES);
    localparam int LP_W       = 2 * ADDR_W;
    localparam int BIDX_W     = $clog2(BYTE_W);
    localparam int CP_W       = 2 * BIDX_W;
    localparam int CNT_W      = $clog2(PAGE_BYTES + 1);
    localparam int WORD_W     = 2 * BYTE_W;
    localparam int RES_WORDS  = 3;
    localparam int IDX_W      = $clog2(RES_WORDS);

    localparam logic [7:0] MODE_STANDBY = 8'h00;
    localparam logic [7:0] MODE_DATA    = 8'h94;
    localparam logic [7:0] MODE_ECC_CLR = 8'hF4;
    localparam logic [7:0] MODE_ECC_RUN = 8'hB4;
    localparam logic [7:0] MODE_ECC_OUT = 8'hD4;

    typedef struct packed {
        logic [LP_W-1:0]   lp;
        logic [BYTE_W-1:0] col;
    } half_par_t;

    // Spread one byte parity onto the line bit pairs picked by its address.
    function automatic logic [LP_W-1:0] line_mask(input logic [ADDR_W-1:0] a,
                                                  input logic p);
        logic [LP_W-1:0] m;
        m = '0;
        for (int k = 0; k < ADDR_W; k++) begin
            m[2*k]   = p & ~a[k];
            m[2*k+1] = p &  a[k];
        end
        return m;
    endfunction

    // Fold the running column XOR into the column parity pairs.
    function automatic logic [CP_W-1:0] col_pairs(input logic [BYTE_W-1:0] c);
        logic [CP_W-1:0] cp;
        cp = '0;
        for (int j = 0; j < BIDX_W; j++) begin
            for (int b = 0; b < BYTE_W; b++) begin
                if (((b >> j) & 1) != 0) cp[2*j+1] = cp[2*j+1] ^ c[b];
                else                     cp[2*j]   = cp[2*j]   ^ c[b];
            end
        end
        return cp;
    endfunction

    function automatic logic [BYTE_W-1:0] col_byte(input half_par_t h);
        return {~col_pairs(h.col), 2'b11};
    endfunction
endpackage

// File: rtl/pecc_half_acc.sv
module pecc_half_acc
    import pecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] dat,
    output half_par_t         par
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            par <= '0;
        end else if (en) begin
            par.col <= par.col ^ dat;
            par.lp  <= par.lp ^ line_mask(addr, ^dat);
        end
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (par == '0)); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(par)); // R2
endmodule

// File: rtl/pecc_result_mux.sv
module pecc_result_mux
    import pecc_pkg::*;
(
    input  half_par_t         h_lo,
    input  half_par_t         h_hi,
    input  logic              active,
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);
    logic [BYTE_W-1:0] cb_lo, cb_hi;

    always_comb begin
        cb_lo = col_byte(h_lo);
        cb_hi = col_byte(h_hi);
        word  = '0;
        if (active) begin
            case (idx)
                2'd0:    word = {~h_lo.lp[15:8], ~h_lo.lp[7:0]};
                2'd1:    word = {~h_hi.lp[7:0], cb_lo};
                default: word = {cb_hi, ~h_hi.lp[15:8]};
            endcase
        end
    end
endmodule

// File: rtl/page_ecc_gen.sv
module page_ecc_gen
    import pecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [7:0]        mode_wdata,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_dat,
    input  logic              word_rd,
    output logic [WORD_W-1:0] word_rdata,
    output logic [7:0]        mode_q
);
    localparam int HSEL_W = CNT_W - ADDR_W;

    logic [7:0]       mode_r;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic             calc, outm, clr, take;
    half_par_t        par [HALVES];

    assign calc   = (mode_r == MODE_ECC_RUN);
    assign outm   = (mode_r == MODE_ECC_OUT);
    assign clr    = mode_wr && (mode_wdata == MODE_ECC_CLR);
    assign take   = calc && byte_vld && !mode_wr && (cnt < CNT_W'(PAGE_BYTES));
    assign mode_q = mode_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_r <= MODE_STANDBY;
            cnt    <= '0;
            idx    <= '0;
        end else begin
            if (mode_wr) begin
                mode_r <= mode_wdata;
                if (mode_wdata == MODE_ECC_CLR) cnt <= '0;
                if (mode_wdata == MODE_ECC_OUT) idx <= '0;
            end else if (outm && word_rd) begin
                if (idx == IDX_W'(RES_WORDS - 1)) begin
                    mode_r <= MODE_DATA;
                    idx    <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
            if (take) cnt <= cnt + 1'b1;
        end
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic en_h;
        assign en_h = take && (cnt[CNT_W-1:ADDR_W] == HSEL_W'(h));
        pecc_half_acc u_acc (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr),
            .en   (en_h),
            .addr (cnt[ADDR_W-1:0]),
            .dat  (byte_dat),
            .par  (par[h])
        );
    end

    pecc_result_mux u_mux (
        .h_lo   (par[0]),
        .h_hi   (par[1]),
        .active (outm),
        .idx    (idx),
        .word   (word_rdata)
    );

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(PAGE_BYTES)); // R3
    AST_CLR_COUNT: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0)); // R1
    AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!calc && !clr) |=> $stable(cnt)); // R2
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        idx < IDX_W'(RES_WORDS)); // R7
    AST_OUT_RETURN: assert property (@(posedge clk) disable iff (rst)
        (outm && word_rd && !mode_wr && idx == IDX_W'(RES_WORDS - 1))
        |=> (mode_q == MODE_DATA)); // R8
    AST_MODE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (mode_q == $past(mode_wdata))); // R9
endmodule

// File: tb/page_ecc_gen_bench.sv
module page_ecc_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr = 1'b0;
    logic [7:0]  mode_wdata = '0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_dat = '0;
    logic        word_rd = 1'b0;
    logic [15:0] word_rdata;
    logic [7:0]  mode_q;

    int checks = 0;
    int errors = 0;
    logic [7:0] pg [512];

    always #(CLK_PERIOD/2) clk = ~clk;

    page_ecc_gen u_page_ecc_gen (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .byte_vld(byte_vld), .byte_dat(byte_dat), .word_rd(word_rd),
        .word_rdata(word_rdata), .mode_q(mode_q)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [7:0] m);
        mode_wr = 1'b1; mode_wdata = m;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic pulse_rd();
        word_rd = 1'b1;
        @(negedge clk);
        word_rd = 1'b0;
    endtask

    task automatic feed_page(input int n);
        for (int i = 0; i < n; i++) begin
            byte_vld = 1'b1; byte_dat = pg[i % 512];
            @(negedge clk);
        end
        byte_vld = 1'b0;
    endtask

    // Expected check bytes of one half, from the bit-level definitions.
    task automatic model_half(input int base, output logic [15:0] lp, output logic [7:0] cb);
        logic [5:0] cp;
        lp = '0; cp = '0;
        for (int i = 0; i < 256; i++) begin
            logic [7:0] d;
            d = pg[base + i];
            for (int k = 0; k < 8; k++) begin
                if (((i >> k) & 1) != 0) lp[2*k+1] ^= ^d;
                else                     lp[2*k]   ^= ^d;
            end
            for (int b = 0; b < 8; b++)
                for (int j = 0; j < 3; j++) begin
                    if (((b >> j) & 1) != 0) cp[2*j+1] ^= d[b];
                    else                     cp[2*j]   ^= d[b];
                end
        end
        lp = ~lp;
        cb = {~cp, 2'b11};
    endtask

    task automatic read_and_check(input string tag);
        logic [15:0] l0, l1;
        logic [7:0]  c0, c1;
        model_half(0, l0, c0);
        model_half(256, l1, c1);
        set_mode(8'hD4);
        chk({tag, " R7 word0"}, word_rdata, {l0[15:8], l0[7:0]});
        pulse_rd();
        chk({tag, " R7 word1"}, word_rdata, {l1[7:0], c0});
        pulse_rd();
        chk({tag, " R7 word2"}, word_rdata, {c1, l1[15:8]});
        pulse_rd();
        chk({tag, " R8 mode back to data"}, {8'h0, mode_q}, 16'h0094);
        chk({tag, " R8 rdata zero outside result"}, word_rdata, 16'h0000);
    endtask

    task automatic t_reset();
        chk("R9 reset mode", {8'h0, mode_q}, 16'h0000);
        chk("R8 reset rdata", word_rdata, 16'h0000);
    endtask

    task automatic t_erased();
        set_mode(8'hF4);
        chk("R9 mode after write", {8'h0, mode_q}, 16'h00F4);
        pulse_rd();
        chk("R1 dummy read keeps mode", {8'h0, mode_q}, 16'h00F4);
        set_mode(8'hB4);
        for (int i = 0; i < 512; i++) pg[i] = 8'hFF;
        feed_page(512);
        read_and_check("R6 erased");
    endtask

    task automatic t_pattern();
        for (int i = 0; i < 512; i++) pg[i] = 8'((i * 37 + 11) ^ (i >> 3));
        set_mode(8'hF4);
        pulse_rd();
        set_mode(8'hB4);
        feed_page(512);
        read_and_check("R4 R5 pattern");
    endtask

    task automatic t_clear();
        set_mode(8'hF4);
        for (int i = 0; i < 512; i++) pg[i] = 8'h00;
        read_and_check("R1 cleared");
    endtask

    task automatic t_ignore();
        set_mode(8'hF4);
        pulse_rd();
        for (int i = 0; i < 512; i++) pg[i] = 8'hA5 ^ 8'(i);
        set_mode(8'h94);
        feed_page(40);               // R2 data mode bytes ignored
        set_mode(8'hB4);
        pg[300] = pg[300] ^ 8'h10;   // R3 single bit in second half
        feed_page(512);
        for (int i = 0; i < 20; i++) begin   // R3 bytes past 512 ignored
            byte_vld = 1'b1; byte_dat = 8'(i * 13 + 1);
            @(negedge clk);
        end
        byte_vld = 1'b0;
        read_and_check("R2 R3 ignore");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                t_reset();
                t_erased();
                t_pattern();
                t_clear();
                t_ignore();
            end
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule